// File: doc/BRIEF.md
# Slave Lock State Tracker

This block keeps the lock state of one slave unit on a multi-master serial bus. While locked, the unit answers only to the master that locked it. Every cycle the frame layer presents the results of the current frame: the decoded control code, a broadcast indication, the declared message length, the number of data bytes completed so far and the address of the master. A single-cycle end-of-frame strobe tells the tracker to act on them.

- A lock-type frame that stops before it has carried all of its declared bytes locks the unit to its master.
- A lock-type or unlock frame that carries all of its declared bytes releases the unit.

A deep-standby entry pulse, a software unlock strobe or reset also release the unit, independently of any frame. The tracker drives:

- a lock flag;
- the stored master address;
- a slave status byte whose bit 2 mirrors the lock.

Top module: `slk_tracker`

## Requirements
- R1: After reset is asserted, `locked_o` is 0, `lock_master_o` is 0 and `status_o` is 0x00.
- R2: An end-of-frame strobe on a frame that is not broadcast, whose control code is 0x3, 0xA or 0xB and whose completed byte count is below the declared length, sets `locked_o` one cycle later and stores `master_addr_i` in `lock_master_o`. This applies while the unit is unlocked, or while it is locked to that same master.
- R3: A frame from an accepted master with control code 0x3, 0xA or 0xB and a byte count at or above the declared length leaves the unit unlocked, with `lock_master_o` at 0.
- R4: Control code 0x6 with a complete byte count from an accepted master unlocks the unit. Control code 0x6 with a short byte count changes nothing.
- R5: A frame with `bcast_i` = 1 never changes `locked_o` or `lock_master_o`.
- R6: While locked, a frame whose master address differs from `lock_master_o` changes neither output, whatever its control code.
- R7: A one-cycle `standby_i` pulse clears the lock in the next cycle.
- R8: A one-cycle `sw_unlock_i` strobe clears the lock in the next cycle.
- R9: When `standby_i` or `sw_unlock_i` is high in the same cycle as a frame that would set the lock, the unit ends up unlocked.
- R10: Bit 2 of `status_o` always equals `locked_o`, and every other status bit is 0.
- R11: Without the end-of-frame strobe, the frame inputs have no effect on the lock state.
- R12: Control codes other than 0x3, 0x6, 0xA and 0xB never change the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_end_i | input | 1 | Single-cycle end-of-frame strobe |
| ctrl_i | input | 4 | Decoded control code of the frame |
| bcast_i | input | 1 | Frame is a broadcast |
| msg_len_i | input | LEN_W | Declared message length in bytes |
| byte_cnt_i | input | LEN_W | Data bytes completed in the frame |
| master_addr_i | input | ADDR_W | Address of the frame's master |
| standby_i | input | 1 | Deep-standby entry pulse |
| sw_unlock_i | input | 1 | Software unlock strobe |
| locked_o | output | 1 | Lock state |
| lock_master_o | output | ADDR_W | Address of the locking master, 0 when unlocked |
| status_o | output | 8 | Slave status byte, bit 2 = lock |

## Verification
The bench targets these corner cases:

- **Short versus full byte count.** A design that swapped the comparison would lock on complete frames and release on short ones.
- **A foreign master sending a complete unlock frame to a locked unit.** A design without the ownership check would let any master break the lock.
- **Broadcast frames that would otherwise lock or unlock.** A design that ignored the broadcast flag would change state on them.
- **Control codes that do nothing.** Code 0x6 with a short count and unlisted codes such as 0xF must leave the state alone.
- **An unlock cause in the same cycle as a lock-setting frame.** A design with the priority inverted would come out locked.

// File: rtl/slk_pkg.sv
package slk_pkg;
  localparam int CTRL_W = 4;
  typedef logic [CTRL_W-1:0] ctrl_t;

  localparam ctrl_t CTRL_LOCK_0 = 4'h3;
  localparam ctrl_t CTRL_LOCK_1 = 4'hA;
  localparam ctrl_t CTRL_LOCK_2 = 4'hB;
  localparam ctrl_t CTRL_UNLOCK = 4'h6;

  localparam int STAT_W   = 8;
  localparam int LOCK_BIT = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } lock_act_e;

  function automatic logic is_lock_ctrl(ctrl_t c);
    return (c == CTRL_LOCK_0) || (c == CTRL_LOCK_1) || (c == CTRL_LOCK_2);
  endfunction
endpackage

// File: rtl/slk_frame_eval.sv
module slk_frame_eval
  import slk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              frame_end_i,
  input  ctrl_t             ctrl_i,
  input  logic              bcast_i,
  input  logic [LEN_W-1:0]  msg_len_i,
  input  logic [LEN_W-1:0]  byte_cnt_i,
  input  logic [ADDR_W-1:0] master_addr_i,
  input  logic              locked_i,
  input  logic [ADDR_W-1:0] lock_master_i,
  output lock_act_e         act_o
);
  logic complete;
  logic owner_ok;

  assign complete = (byte_cnt_i >= msg_len_i);
  // a locked unit listens only to its owner
  assign owner_ok = !locked_i || (master_addr_i == lock_master_i);

  always_comb begin
    act_o = ACT_NONE;
    if (frame_end_i && !bcast_i && owner_ok) begin
      if (is_lock_ctrl(ctrl_i)) begin
        act_o = complete ? ACT_CLR : ACT_SET;
      end else if (ctrl_i == CTRL_UNLOCK && complete) begin
        act_o = ACT_CLR;
      end
    end
  end
endmodule

// File: rtl/slk_lock_reg.sv
module slk_lock_reg
  import slk_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lock_act_e         act_i,
  input  logic              local_clr_i,
  input  logic [ADDR_W-1:0] master_addr_i,
  output logic              locked_o,
  output logic [ADDR_W-1:0] lock_master_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o      <= 1'b0;
      lock_master_o <= '0;
    end else if (local_clr_i || act_i == ACT_CLR) begin
      // local causes win over a set in the same cycle
      locked_o      <= 1'b0;
      lock_master_o <= '0;
    end else if (act_i == ACT_SET) begin
      locked_o      <= 1'b1;
      lock_master_o <= master_addr_i;
    end
  end
endmodule

// File: rtl/slk_tracker.sv
module slk_tracker
  import slk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  input  logic [3:0]        ctrl_i,
  input  logic              bcast_i,
  input  logic [LEN_W-1:0]  msg_len_i,
  input  logic [LEN_W-1:0]  byte_cnt_i,
  input  logic [ADDR_W-1:0] master_addr_i,
  input  logic              standby_i,
  input  logic              sw_unlock_i,
  output logic              locked_o,
  output logic [ADDR_W-1:0] lock_master_o,
  output logic [7:0]        status_o
);
  lock_act_e act;
  logic      local_clr;

  assign local_clr = standby_i | sw_unlock_i;

  slk_frame_eval #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_eval (
    .frame_end_i  (frame_end_i),
    .ctrl_i       (ctrl_i),
    .bcast_i      (bcast_i),
    .msg_len_i    (msg_len_i),
    .byte_cnt_i   (byte_cnt_i),
    .master_addr_i(master_addr_i),
    .locked_i     (locked_o),
    .lock_master_i(lock_master_o),
    .act_o        (act)
  );

  slk_lock_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_i        (act),
    .local_clr_i  (local_clr),
    .master_addr_i(master_addr_i),
    .locked_o     (locked_o),
    .lock_master_o(lock_master_o)
  );

  always_comb begin
    status_o           = '0;
    status_o[LOCK_BIT] = locked_o;
  end
endmodule

// File: rtl/slk_tracker_chk.sv
module slk_tracker_chk #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_end_i,
  input logic [3:0]        ctrl_i,
  input logic              bcast_i,
  input logic [LEN_W-1:0]  msg_len_i,
  input logic [LEN_W-1:0]  byte_cnt_i,
  input logic [ADDR_W-1:0] master_addr_i,
  input logic              standby_i,
  input logic              sw_unlock_i,
  input logic              locked_o,
  input logic [ADDR_W-1:0] lock_master_o,
  input logic [7:0]        status_o
);
  logic quiet;
  logic lock_code;
  logic owner;

  assign quiet     = !standby_i && !sw_unlock_i;
  assign lock_code = (ctrl_i == 4'h3) || (ctrl_i == 4'hA) || (ctrl_i == 4'hB);
  assign owner     = !locked_o || (master_addr_i == lock_master_o);

  AST_STATUS_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2] == locked_o) && (status_o[7:3] == 5'd0) && (status_o[1:0] == 2'd0)); // R10
  AST_LOCK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i && !bcast_i && lock_code && (byte_cnt_i < msg_len_i) && owner && quiet
    |=> locked_o && (lock_master_o == $past(master_addr_i))); // R2
  AST_BCAST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i && bcast_i && quiet |=> $stable(locked_o) && $stable(lock_master_o)); // R5
  AST_FOREIGN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i && locked_o && (master_addr_i != lock_master_o) && quiet
    |=> $stable(locked_o) && $stable(lock_master_o)); // R6
  AST_STANDBY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !locked_o); // R7
  AST_SW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_unlock_i |=> !locked_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i && quiet |=> $stable(locked_o) && $stable(lock_master_o)); // R11
endmodule

bind slk_tracker slk_tracker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_end_i  (frame_end_i),
  .ctrl_i       (ctrl_i),
  .bcast_i      (bcast_i),
  .msg_len_i    (msg_len_i),
  .byte_cnt_i   (byte_cnt_i),
  .master_addr_i(master_addr_i),
  .standby_i    (standby_i),
  .sw_unlock_i  (sw_unlock_i),
  .locked_o     (locked_o),
  .lock_master_o(lock_master_o),
  .status_o     (status_o)
);

// File: tb/sim_slk_tracker.sv
`timescale 1ns/1ps
module sim_slk_tracker;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              frame_end_i = 1'b0;
  logic [3:0]        ctrl_i = 4'h0;
  logic              bcast_i = 1'b0;
  logic [LEN_W-1:0]  msg_len_i = '0;
  logic [LEN_W-1:0]  byte_cnt_i = '0;
  logic [ADDR_W-1:0] master_addr_i = '0;
  logic              standby_i = 1'b0;
  logic              sw_unlock_i = 1'b0;
  logic              locked_o;
  logic [ADDR_W-1:0] lock_master_o;
  logic [7:0]        status_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  slk_tracker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_state(input bit lk, input int mst, input string req);
    check(locked_o == lk, req, int'(locked_o), int'(lk));
    check(lock_master_o == ADDR_W'(mst), req, int'(lock_master_o), mst);
    check(status_o == (lk ? 8'h04 : 8'h00), {req, "/R10"}, int'(status_o), lk ? 4 : 0);
  endtask

  // one frame end strobe; outputs checked after the capturing edge
  task automatic frame(input logic [3:0] c, input bit bc, input int len, input int cnt,
                       input int addr, input bit sb, input bit sw);
    @(negedge clk_i);
    ctrl_i = c; bcast_i = bc; msg_len_i = LEN_W'(len); byte_cnt_i = LEN_W'(cnt);
    master_addr_i = ADDR_W'(addr); standby_i = sb; sw_unlock_i = sw; frame_end_i = 1'b1;
    @(negedge clk_i);
    frame_end_i = 1'b0; standby_i = 1'b0; sw_unlock_i = 1'b0;
  endtask

  task automatic pulse(input bit sb, input bit sw);
    @(negedge clk_i);
    standby_i = sb; sw_unlock_i = sw;
    @(negedge clk_i);
    standby_i = 1'b0; sw_unlock_i = 1'b0;
  endtask

  task automatic t_reset();
    expect_state(1'b0, 0, "R1");
  endtask

  task automatic t_lock_short();
    frame(4'h3, 0, 5, 2, 'h123, 0, 0);
    expect_state(1'b1, 'h123, "R2");
  endtask

  task automatic t_foreign();
    frame(4'h6, 0, 4, 4, 'h456, 0, 0);
    expect_state(1'b1, 'h123, "R6");
    frame(4'hA, 0, 4, 1, 'h456, 0, 0);
    expect_state(1'b1, 'h123, "R6");
  endtask

  task automatic t_bcast_locked();
    frame(4'h6, 1, 3, 3, 'h123, 0, 0);
    expect_state(1'b1, 'h123, "R5");
  endtask

  task automatic t_other_ctrl();
    frame(4'hF, 0, 2, 2, 'h123, 0, 0);
    expect_state(1'b1, 'h123, "R12");
    frame(4'h0, 0, 2, 9, 'h123, 0, 0);
    expect_state(1'b1, 'h123, "R12");
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    ctrl_i = 4'h6; bcast_i = 0; msg_len_i = 2; byte_cnt_i = 2; master_addr_i = 'h123;
    repeat (3) @(negedge clk_i);
    expect_state(1'b1, 'h123, "R11");
  endtask

  task automatic t_unlock_code();
    frame(4'h6, 0, 6, 3, 'h123, 0, 0);
    expect_state(1'b1, 'h123, "R4");
    frame(4'h6, 0, 6, 6, 'h123, 0, 0);
    expect_state(1'b0, 0, "R4");
  endtask

  task automatic t_lock_complete();
    frame(4'hB, 0, 8, 0, 'h007, 0, 0);
    expect_state(1'b1, 'h007, "R2");
    frame(4'h3, 0, 8, 1, 'h007, 0, 0);
    expect_state(1'b1, 'h007, "R2");
    frame(4'hA, 0, 8, 8, 'h007, 0, 0);
    expect_state(1'b0, 0, "R3");
    frame(4'h3, 0, 2, 3, 'h055, 0, 0);
    expect_state(1'b0, 0, "R3");
  endtask

  task automatic t_bcast_unlocked();
    frame(4'h3, 1, 5, 1, 'h0AA, 0, 0);
    expect_state(1'b0, 0, "R5");
  endtask

  task automatic t_standby();
    frame(4'hA, 0, 4, 0, 'h321, 0, 0);
    expect_state(1'b1, 'h321, "R2");
    pulse(1, 0);
    expect_state(1'b0, 0, "R7");
  endtask

  task automatic t_sw();
    frame(4'hB, 0, 4, 2, 'h0F0, 0, 0);
    expect_state(1'b1, 'h0F0, "R2");
    pulse(0, 1);
    expect_state(1'b0, 0, "R8");
  endtask

  task automatic t_priority();
    frame(4'h3, 0, 5, 1, 'h111, 0, 1);
    expect_state(1'b0, 0, "R9");
    frame(4'hA, 0, 5, 1, 'h111, 1, 0);
    expect_state(1'b0, 0, "R9");
  endtask

  task automatic t_reset_locked();
    frame(4'h3, 0, 5, 1, 'h222, 0, 0);
    expect_state(1'b1, 'h222, "R2");
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    expect_state(1'b0, 0, "R1");
    rst_ni = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_lock_short();
    t_foreign();
    t_bcast_locked();
    t_other_ctrl();
    t_idle();
    t_unlock_code();
    t_lock_complete();
    t_bcast_unlocked();
    t_standby();
    t_sw();
    t_priority();
    t_reset_locked();
    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule